// File: doc/BRIEF.md
# Recursive Systematic Rate-1/2 Convolutional Encoder

This block turns a stream of information bits into a stream of coded bit pairs at code rate one half. Each accepted input bit leaves in the same cycle as a pair made of the bit itself and one parity bit. The code is recursive. A two-bit register (four trellis states) is fed by the data bit XORed with a feedback term from the generator 1+D^2. The parity bit comes from the generator 1+D+D^2, applied to the register input and the two delayed bits. The coded pairs are meant for a block interleaver downstream, so their bit order is fixed.

Both sides of the block use valid/ready handshakes. Backpressure passes straight through: while the consumer holds `out_ready` low, `in_ready` is low and the register keeps its value. A `frame_start` pulse zeroes the register. A `term_req` pulse after the last data bit starts a tail of two extra pairs. During the tail the encoder picks its own input so that the register returns to the all-zero state.

The controller has two states:
- `ENC_RUN`: passes data through.
- `ENC_TAIL`: emits the tail pairs.

It has these transitions:
- RUN→RUN on `frame_start` (clear).
- RUN→TAIL on `term_req` (terminate).
- TAIL→TAIL on an accepted non-final tail pair (tail step).
- TAIL→RUN on an accepted final tail pair (tail done).
- TAIL→RUN on `frame_start` (abort).

Top module: `rsc_encoder_top`

## Requirements
- R1: For every accepted input bit, one pair is presented in the same cycle with `out_valid` high. `out_pair[0]` is the input bit (systematic) and `out_pair[1]` is the parity bit.
- R2: With register bits s1 (one cycle old) and s2 (two cycles old), the register input is w = u XOR s2. The parity is w XOR s1 XOR s2. After each accepted beat, s1 takes w and s2 takes the old s1.
- R3: After reset the register is zero and the controller is in RUN. `out_valid` is low while `in_valid` is low, and `out_last` is low.
- R4: While `frame_start` is high, `in_ready` and `out_valid` are low and no data is consumed. Afterwards the register is zero, so the next bit u is coded with parity u.
- R5: While `out_ready` is low, `in_ready` is low and the register does not change. A stalled pair stays valid with the same value.
- R6: `term_req` in RUN consumes no data and leads to exactly two tail pairs. In each tail pair the systematic bit equals s2 and the parity follows R2.
- R7: `out_last` is high on the second tail pair only.
- R8: Once the final tail pair is accepted, the register is zero and the controller is back in RUN. The next frame then codes from state zero without a `frame_start`.
- R9: `frame_start` during the tail abandons it, suppresses output in that cycle, and returns to RUN with a zero register.
- R10: While `out_ready` is low during the tail, the pending tail pair is held unchanged and the tail does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Clears the register and returns to RUN |
| term_req | input | 1 | Starts the two-pair tail |
| in_valid | input | 1 | Input bit valid |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Input bit accepted when high together with in_valid |
| out_valid | output | 1 | Coded pair valid |
| out_ready | input | 1 | Consumer accepts the pair |
| out_pair | output | 2 | Bit 0 systematic, bit 1 parity |
| out_last | output | 1 | Marks the final tail pair |

## Verification
A fixed bit sequence is chosen so that its path visits all four trellis states and both feedback values. Its hand-computed pairs separate a wrong feedback tap from a wrong forward tap or a swapped output order. Random frames with random stalls are compared against an independent model. These show whether a stall advances the register or changes a held pair. Back-to-back frames that rely only on termination, and frames restarted by `frame_start`, distinguish a register truly flushed to zero from one that only looks idle: after a flush the first pair of the next frame must carry parity equal to its data bit. A `frame_start` issued in the middle of the tail shows whether an abort leaves the register or the tail count behind.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [0:0] {
        ENC_RUN  = 1'b0,
        ENC_TAIL = 1'b1
    } enc_state_e;

endpackage

// File: rtl/rsc_trellis.sv
// Shift register and combinational coding logic of the recursive encoder.
// Polynomial bit k is the coefficient of D^k; state bit k-1 holds D^k.
module rsc_trellis #(
    parameter int              MEM     = 2,
    parameter logic [MEM:0]    FB_POLY = 3'b101,
    parameter logic [MEM:0]    FF_POLY = 3'b111
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           advance,
    input  logic           tail_mode,
    input  logic           data_bit,
    output logic           sys_bit,
    output logic           par_bit,
    output logic [MEM-1:0] state_q
);

    logic [MEM-1:0] fb_taps;
    logic [MEM-1:0] ff_taps;
    logic           fb_sum;
    logic           ff_sum;
    logic           reg_in;
    logic [MEM:0]   shifted;

    assign fb_taps = FB_POLY[MEM:1];
    assign ff_taps = FF_POLY[MEM:1];

    always_comb begin
        fb_sum = ^(state_q & fb_taps);
        ff_sum = ^(state_q & ff_taps);
        // during the tail the input cancels the feedback so the register fills with zeros
        sys_bit = tail_mode ? fb_sum : data_bit;
        reg_in  = sys_bit ^ fb_sum;
        par_bit = (FF_POLY[0] & reg_in) ^ ff_sum;
        shifted = {state_q, reg_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (clear) begin
            state_q <= '0;
        end else if (advance) begin
            state_q <= shifted[MEM-1:0];
        end
    end

    // R4: a clear empties the register
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state_q == '0));

    // R5: without an advance the register holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clear) |=> $stable(state_q));

endmodule

// File: rtl/rsc_ctrl.sv
// Handshake and termination controller.
module rsc_ctrl
    import rsc_pkg::*;
#(
    parameter int MEM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic term_req,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic out_last,
    output logic tail_mode,
    output logic advance,
    output logic clear
);

    localparam int CW = (MEM > 1) ? $clog2(MEM) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(MEM - 1);

    enc_state_e       state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;

    // next-state logic and state register
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ENC_RUN: begin
                if (frame_start) begin
                    state_d = ENC_RUN;
                end else if (term_req) begin
                    state_d = ENC_TAIL;
                    cnt_d   = '0;
                end
            end
            ENC_TAIL: begin
                if (frame_start) begin
                    state_d = ENC_RUN;
                    cnt_d   = '0;
                end else if (out_ready) begin
                    if (cnt_q == LAST_CNT) begin
                        state_d = ENC_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = ENC_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENC_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output logic
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        tail_mode = 1'b0;
        advance   = 1'b0;
        clear     = frame_start;
        unique case (state_q)
            ENC_RUN: begin
                in_ready  = out_ready && !frame_start && !term_req;
                out_valid = in_valid && !frame_start && !term_req;
                advance   = in_valid && in_ready;
            end
            ENC_TAIL: begin
                tail_mode = 1'b1;
                out_valid = !frame_start;
                out_last  = !frame_start && (cnt_q == LAST_CNT);
                advance   = out_ready && !frame_start;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

    // R5: input is never accepted while the consumer stalls
    p_ready_needs_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);

    // R4: frame start blocks both sides in its cycle
    p_fs_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (!in_ready && !out_valid));

    // R10: a stalled tail pair stays presented
    p_tail_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && tail_mode && !frame_start) |=>
            (out_valid || $past(frame_start) || frame_start));

endmodule

// File: rtl/rsc_encoder_top.sv
module rsc_encoder_top #(
    parameter int           MEM     = 2,
    parameter logic [MEM:0] FB_POLY = 3'b101,
    parameter logic [MEM:0] FF_POLY = 3'b111
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       term_req,
    input  logic       in_valid,
    input  logic       in_bit,
    output logic       in_ready,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [1:0] out_pair,
    output logic       out_last
);

    logic           tail_mode;
    logic           advance;
    logic           clear;
    logic           sys_bit;
    logic           par_bit;
    logic [MEM-1:0] trellis_state;

    rsc_ctrl #(
        .MEM (MEM)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .term_req    (term_req),
        .in_valid    (in_valid),
        .out_ready   (out_ready),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_last    (out_last),
        .tail_mode   (tail_mode),
        .advance     (advance),
        .clear       (clear)
    );

    rsc_trellis #(
        .MEM     (MEM),
        .FB_POLY (FB_POLY),
        .FF_POLY (FF_POLY)
    ) u_trellis (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .advance   (advance),
        .tail_mode (tail_mode),
        .data_bit  (in_bit),
        .sys_bit   (sys_bit),
        .par_bit   (par_bit),
        .state_q   (trellis_state)
    );

    assign out_pair = {par_bit, sys_bit};

    // R1: outside the tail the systematic bit is the input bit
    p_systematic_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !tail_mode) |-> (out_pair[0] == in_bit));

    // R8: accepting the final tail pair leaves the register empty
    p_flushed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (trellis_state == '0));

    // R7: last is only flagged on a valid pair
    p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

endmodule

// File: tb/rsc_encoder_top_tb.sv
module rsc_encoder_top_tb;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 14;
    // {tail, in_bit, parity, systematic, last}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b0_1_11_0, 5'b0_0_10_0, 5'b0_1_11_0, 5'b0_1_11_0,
        5'b0_0_10_0, 5'b0_0_00_0, 5'b0_1_01_0, 5'b0_0_10_0,
        5'b0_1_01_0, 5'b0_1_11_0, 5'b0_1_11_0, 5'b0_0_10_0,
        5'b1_0_11_0, 5'b1_0_00_1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       term_req = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [1:0] out_pair;
    logic       out_last;

    int n_checks = 0;
    int n_fail   = 0;
    logic m1 = 1'b0;
    logic m2 = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rsc_encoder_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .term_req    (term_req),
        .in_valid    (in_valid),
        .in_bit      (in_bit),
        .in_ready    (in_ready),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_pair    (out_pair),
        .out_last    (out_last)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference pair for input u from model state; returns {parity, sys}
    function automatic logic [1:0] ref_pair(input logic u);
        logic w;
        w = u ^ m2;
        return {w ^ m1 ^ m2, u};
    endfunction

    task automatic ref_step(input logic u);
        logic w;
        w  = u ^ m2;
        m2 = m1;
        m1 = w;
    endtask

    task automatic idle_inputs();
        frame_start = 1'b0;
        term_req    = 1'b0;
        in_valid    = 1'b0;
        out_ready   = 1'b1;
    endtask

    // one data beat, consumer ready
    task automatic send_bit(input string req, input logic u);
        @(negedge clk);
        idle_inputs();
        in_valid = 1'b1;
        in_bit   = u;
        #2;
        chk({req, " ready"}, int'(in_ready), 1);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " pair"}, int'(out_pair), int'(ref_pair(u)));
        ref_step(u);
    endtask

    task automatic do_frame_start(input string req);
        @(negedge clk);
        idle_inputs();
        frame_start = 1'b1;
        in_valid    = 1'b1;
        #2;
        chk({req, " fs in_ready"}, int'(in_ready), 0);
        chk({req, " fs out_valid"}, int'(out_valid), 0);
        m1 = 1'b0;
        m2 = 1'b0;
    endtask

    task automatic terminate(input string req);
        logic [1:0] exp;
        @(negedge clk);
        idle_inputs();
        term_req = 1'b1;
        in_valid = 1'b1;
        #2;
        chk({req, " term in_ready"}, int'(in_ready), 0);
        chk({req, " term out_valid"}, int'(out_valid), 0);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            idle_inputs();
            #2;
            exp = ref_pair(m2);
            chk({req, " tail valid"}, int'(out_valid), 1);
            chk({req, " tail pair"}, int'(out_pair), int'(exp));
            chk({"R7 tail last"}, int'(out_last), (k == 1) ? 1 : 0);
            ref_step(m2);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [4:0] v;
        logic       prev_tail;
        repeat (3) @(negedge clk);
        #2;
        // R3: reset state
        chk("R3 out_valid idle", int'(out_valid), 0);
        chk("R3 out_last idle", int'(out_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        chk("R3 in_ready after reset", int'(in_ready), 1);

        // vector table: fixed frame and its tail (R1 R2 R6 R7)
        prev_tail = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            if (v[4] && !prev_tail) begin
                @(negedge clk);
                idle_inputs();
                term_req = 1'b1;
                #2;
                chk("R6 term consumes none", int'(out_valid), 0);
            end
            @(negedge clk);
            idle_inputs();
            if (!v[4]) begin
                in_valid = 1'b1;
                in_bit   = v[3];
            end
            #2;
            chk(v[4] ? "R6 tail vec valid" : "R1 vec valid", int'(out_valid), 1);
            chk(v[4] ? "R6 tail vec pair" : "R2 vec pair", int'(out_pair), int'(v[2:1]));
            chk("R7 vec last", int'(out_last), int'(v[0]));
            prev_tail = v[4];
        end
        m1 = 1'b0;
        m2 = 1'b0;

        // R8: next frame starts from zero without frame_start
        send_bit("R8 first after flush", 1'b1);
        chk("R8 parity equals data", int'(out_pair[1]), 1);
        send_bit("R8 second", 1'b1);

        // R4: frame_start clears mid-frame
        send_bit("R2 pre", 1'b0);
        do_frame_start("R4");
        send_bit("R4 first after clear", 1'b0);
        chk("R4 parity equals data", int'(out_pair[1]), 0);
        send_bit("R4 second", 1'b1);

        // R5: stall holds pair and register, then random frames with stalls
        for (int f = 0; f < 40; f++) begin
            int len;
            len = 3 + int'($urandom_range(0, 20));
            for (int b = 0; b < len; b++) begin
                logic u;
                u = 1'($urandom_range(0, 1));
                if ($urandom_range(0, 3) == 0) begin
                    @(negedge clk);
                    idle_inputs();
                    in_valid  = 1'b1;
                    in_bit    = u;
                    out_ready = 1'b0;
                    #2;
                    chk("R5 stall in_ready", int'(in_ready), 0);
                    chk("R5 stall pair", int'(out_pair), int'(ref_pair(u)));
                end
                send_bit("R2 random", u);
            end
            if (f % 3 == 0) begin
                terminate("R6 random");
            end else if (f % 3 == 1) begin
                do_frame_start("R4 random");
            end
            // frames with f%3==2 run back to back into the next frame
        end

        // R10: stall during tail, then R9 abort during tail
        send_bit("R2 pre tail", 1'b1);
        send_bit("R2 pre tail", 1'b0);
        @(negedge clk);
        idle_inputs();
        term_req = 1'b1;
        @(negedge clk);
        idle_inputs();
        out_ready = 1'b0;
        #2;
        chk("R10 stalled tail valid", int'(out_valid), 1);
        chk("R10 stalled tail pair", int'(out_pair), int'(ref_pair(m2)));
        chk("R10 stalled last", int'(out_last), 0);
        @(negedge clk);
        out_ready = 1'b0;
        #2;
        chk("R10 tail held", int'(out_pair), int'(ref_pair(m2)));
        chk("R10 still first tail", int'(out_last), 0);
        @(negedge clk);
        idle_inputs();
        #2;
        chk("R10 first tail accepted", int'(out_pair), int'(ref_pair(m2)));
        ref_step(m2);
        do_frame_start("R9 abort");
        @(negedge clk);
        idle_inputs();
        #2;
        chk("R9 back in run no output", int'(out_valid), 0);
        chk("R9 in_ready", int'(in_ready), 1);
        send_bit("R9 after abort", 1'b1);
        chk("R9 zero state parity", int'(out_pair[1]), 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule